// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block turns a three-wire stereo audio stream (bit clock, word clock and serial data) into parallel 24-bit signed left and right samples. All three serial lines are synchronized into the block's own system clock, and the rising edges of the bit clock are detected there. Sampling, word assembly and channel steering all take place in that one clock domain.

A two-bit format input picks one of four framings at run time. The framings differ in where each word sits relative to the word-clock transition: it can start one bit clock after the transition, start at the transition itself, or end right at the next transition with 24 or 16 significant bits. A frame strobe tells downstream logic that both halves of a stereo frame are ready to read.

Top module: `sai_rx`

## Requirements
- R1: The format input selects the framing: 2'b00 one-bit-delayed (word clock low = left), 2'b01 left-aligned, 2'b10 right-aligned 24-bit, 2'b11 right-aligned 16-bit (word clock high = left for the last three).
- R2: Serial data is taken on the rising edge of the bit clock, most significant bit first, two's complement.
- R3: In left-aligned mode the most significant bit is the bit taken on the first bit-clock rise after the word clock changes, and word clock high marks the left word.
- R4: In one-bit-delayed mode the most significant bit is taken one bit clock after the first rise that sees the changed word clock, and word clock low marks the left word. A word that is as long as its slot count ends in the next word's first slot.
- R5: In right-aligned 24-bit mode the sample is the last 24 bits taken before the word clock changes, and any bits before them have no effect.
- R6: In right-aligned 16-bit mode the sample is the last 16 bits before the word clock changes, sign-extended to 24 bits; any bits before them have no effect.
- R7: In left-aligned and one-bit-delayed modes, a word with fewer than 24 bit-clock slots is padded with zeros at the least significant end.
- R8: frame_valid is high for exactly one system clock, one clock after the right output has been updated, and only once per frame. The left update produces no pulse.
- R9: After reset, both sample outputs are zero and frame_valid is low.
- R10: A sample output keeps its value until a complete word for that channel has been received, so a partly received word does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing select, encoded as in R1 |
| sclk | input | 1 | Serial bit clock, asynchronous to clk |
| lrck | input | 1 | Word clock (channel select) |
| sdin | input | 1 | Serial data |
| left_out | output | 24 | Last complete left sample |
| right_out | output | 24 | Last complete right sample |
| frame_valid | output | 1 | One-clock pulse after the right sample is updated |

## Verification
The risky case is a bit-clock rise that ends one word and also carries data. In left-aligned mode, that rise latches the finished word and loads the new word's most significant bit. In one-bit-delayed mode, it appends the last bit of the old word before latching it. The bench provokes both cases with full-scale values that have the top bit set in both channels, and with 16-slot one-bit-delayed words whose last bit falls in the next channel's first slot. It judges them by comparing every captured frame with the value expected from R3, R4 and R7.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

    typedef enum logic [1:0] {
        FMT_DLY1 = 2'b00,
        FMT_LALN = 2'b01,
        FMT_R24  = 2'b10,
        FMT_R16  = 2'b11
    } fmt_e;

    // One synchronized sample of the serial lines
    typedef struct packed {
        logic rise;   // bit-clock rising edge seen this clock
        logic wclk;   // word clock at that edge
        logic dat;    // serial data at that edge
    } ser_evt_t;

    // Word clock level that marks the left channel
    function automatic logic left_level(input fmt_e f);
        return (f != FMT_DLY1);
    endfunction

endpackage

// File: rtl/sai_sync.sv
module sai_sync #(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk,
    input  logic                 lrck,
    input  logic                 sdin,
    output sai_rx_pkg::ser_evt_t evt
);
    import sai_rx_pkg::*;

    localparam int W = 3;

    logic [W-1:0] chain [STAGES];
    logic         sclk_prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else if (i == 0) chain[i] <= {sclk, lrck, sdin};
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            evt       <= '0;
        end else begin
            sclk_prev <= chain[STAGES-1][2];
            evt.rise  <= chain[STAGES-1][2] & ~sclk_prev;
            evt.wclk  <= chain[STAGES-1][1];
            evt.dat   <= chain[STAGES-1][0];
        end
    end

endmodule

// File: rtl/sai_word_asm.sv
module sai_word_asm #(
    parameter int DW = 24,
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sai_rx_pkg::fmt_e     fmt,
    input  sai_rx_pkg::ser_evt_t evt,
    output logic                 done,
    output logic                 is_left,
    output logic [DW-1:0]        word
);
    import sai_rx_pkg::*;

    localparam int CW = $clog2(DW + 1);

    logic          seen;
    logic          prev_wclk;
    logic [DW-1:0] acc;
    logic [DW-1:0] acc_app;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic          boundary;

    always_comb begin
        acc_app = acc;
        if (int'(cnt) < DW) acc_app[DW-1-int'(cnt)] = evt.dat;
        boundary = evt.rise && seen && (evt.wclk != prev_wclk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen      <= 1'b0;
            prev_wclk <= 1'b0;
            acc       <= '0;
            cnt       <= '0;
            shreg     <= '0;
            done      <= 1'b0;
            is_left   <= 1'b0;
            word      <= '0;
        end else begin
            done <= 1'b0;
            if (evt.rise) begin
                seen      <= 1'b1;
                prev_wclk <= evt.wclk;
                shreg     <= {shreg[DW-2:0], evt.dat};
                if (boundary) begin
                    done    <= 1'b1;
                    is_left <= (prev_wclk == left_level(fmt));
                    case (fmt)
                        FMT_LALN: begin
                            word <= acc;
                            acc  <= {evt.dat, {(DW-1){1'b0}}};
                            cnt  <= CW'(1);
                        end
                        FMT_DLY1: begin
                            word <= acc_app;
                            acc  <= '0;
                            cnt  <= '0;
                        end
                        FMT_R24: begin
                            word <= shreg;
                            acc  <= '0;
                            cnt  <= '0;
                        end
                        default: begin
                            word <= {{(DW-SW){shreg[SW-1]}}, shreg[SW-1:0]};
                            acc  <= '0;
                            cnt  <= '0;
                        end
                    endcase
                end else begin
                    acc <= acc_app;
                    if (int'(cnt) < DW) cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // Words complete only on a bit-clock rise (R2)
    p_done_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(evt.rise));

    // Fill count never passes the word width (R7)
    p_cnt_cap_r7: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DW);

endmodule

// File: rtl/sai_rx.sv
module sai_rx #(
    parameter int DW          = 24,
    parameter int SW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    fmt_sel,
    input  logic          sclk,
    input  logic          lrck,
    input  logic          sdin,
    output logic [DW-1:0] left_out,
    output logic [DW-1:0] right_out,
    output logic          frame_valid
);
    import sai_rx_pkg::*;

    fmt_e          fmt;
    ser_evt_t      evt;
    logic          asm_done;
    logic          asm_left;
    logic [DW-1:0] asm_word;
    logic          fv_arm;

    assign fmt = fmt_e'(fmt_sel);

    sai_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .lrck (lrck),
        .sdin (sdin),
        .evt  (evt)
    );

    sai_word_asm #(.DW(DW), .SW(SW)) u_asm (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt),
        .evt     (evt),
        .done    (asm_done),
        .is_left (asm_left),
        .word    (asm_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_out    <= '0;
            right_out   <= '0;
            fv_arm      <= 1'b0;
            frame_valid <= 1'b0;
        end else begin
            fv_arm      <= asm_done && !asm_left;
            frame_valid <= fv_arm;
            if (asm_done && asm_left)  left_out  <= asm_word;
            if (asm_done && !asm_left) right_out <= asm_word;
        end
    end

    p_fv_single_r8: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_fv_after_right_r8: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> $past(asm_done && !asm_left, 2));

    p_r16_sext_r6: assert property (@(posedge clk) disable iff (rst)
        $past(asm_done && !asm_left && fmt == FMT_R16)
        |-> ((&right_out[DW-1:SW-1]) || !(|right_out[DW-1:SW-1])));

    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!frame_valid && left_out == '0 && right_out == '0));

endmodule

// File: tb/sai_rx_tb.sv
module sai_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'b01;
    logic        sclk = 1'b0;
    logic        lrck = 1'b0;
    logic        sdin = 1'b0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        frame_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int fv_count = 0;
    logic        fv_prev = 1'b0;
    logic        carry = 1'b0;
    logic [23:0] cap_l [64];
    logic [23:0] cap_r [64];

    always #10 clk = ~clk;

    sai_rx u_dut (
        .clk         (clk),
        .rst         (rst),
        .fmt_sel     (fmt_sel),
        .sclk        (sclk),
        .lrck        (lrck),
        .sdin        (sdin),
        .left_out    (left_out),
        .right_out   (right_out),
        .frame_valid (frame_valid)
    );

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // Frame capture and pulse-width monitor (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid && fv_prev) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8 got pulse width >1 exp 1");
            end
            if (frame_valid) begin
                if (fv_count < 64) begin
                    cap_l[fv_count] = left_out;
                    cap_r[fv_count] = right_out;
                end
                fv_count++;
            end
        end
        fv_prev = frame_valid;
    end

    task automatic drive_slot(input logic lvl, input logic b);
        @(negedge clk);
        sclk = 1'b0;
        lrck = lvl;
        sdin = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_chan(input logic [1:0] f, input logic [23:0] dat, input int nbits,
                             input int nslots, input logic lvl);
        for (int k = 0; k < nslots; k++) begin
            logic b;
            if (f == 2'b01) b = (k < nbits) ? dat[23-k] : 1'b0;
            else if (f == 2'b00) b = (k == 0) ? carry : ((k-1 < nbits) ? dat[24-k] : 1'b0);
            else begin
                int first;
                first = nslots - nbits;
                b = (k < first) ? 1'b1 : dat[nbits-1-(k-first)];
            end
            drive_slot(lvl, b);
        end
        if (f == 2'b00) carry = (nslots-1 < nbits) ? dat[24-nslots] : 1'b0;
    endtask

    function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [23:0] dat,
                                             input int nbits);
        if (f == 2'b10) return dat;
        if (f == 2'b11) return {{8{dat[15]}}, dat[15:0]};
        return dat & ~((24'd1 << (24 - nbits)) - 24'd1);
    endfunction

    // Lead-in, dummy right word, two frames, then a partial left word
    task automatic run_scn(input string req, input logic [1:0] f,
                           input logic [23:0] l0, input logic [23:0] r0,
                           input logic [23:0] l1, input logic [23:0] r1,
                           input int nbits, input int nslots);
        logic lft;
        int start;
        fmt_sel = f;
        lft = (f != 2'b00);
        carry = 1'b0;
        drive_slot(~lft, 1'b0);
        drive_slot(~lft, 1'b0);
        repeat (10) @(negedge clk);
        start = fv_count;
        send_chan(f, 24'h0, nbits, nslots, ~lft);
        send_chan(f, l0, nbits, nslots, lft);
        send_chan(f, r0, nbits, nslots, ~lft);
        send_chan(f, l1, nbits, nslots, lft);
        send_chan(f, r1, nbits, nslots, ~lft);
        drive_slot(lft, carry);
        drive_slot(lft, 1'b1);
        drive_slot(lft, 1'b1);
        repeat (20) @(negedge clk);
        check({req, " R1 R8 frame count"}, 24'(fv_count - start), 24'd3);
        if (fv_count - start == 3 && start + 2 < 64) begin
            check({req, " left f0"},  cap_l[start+1], exp_word(f, l0, nbits));
            check({req, " right f0"}, cap_r[start+1], exp_word(f, r0, nbits));
            check({req, " left f1"},  cap_l[start+2], exp_word(f, l1, nbits));
            check({req, " right f1"}, cap_r[start+2], exp_word(f, r1, nbits));
        end
        // Partial left word must not change the left output
        check({req, " R10 hold"}, left_out, exp_word(f, l1, nbits));
    endtask

    task automatic test_reset;
        repeat (2) @(negedge clk);
        check("R9 left reset",  left_out,  24'h0);
        check("R9 right reset", right_out, 24'h0);
        check("R9 fv reset",    {23'h0, frame_valid}, 24'h0);
    endtask

    task automatic test_left_aligned;
        run_scn("R3 R2", 2'b01, 24'h800001, 24'hFFFFFF, 24'hA5C3F0, 24'h123456, 24, 32);
    endtask

    task automatic test_delayed;
        run_scn("R4 R2", 2'b00, 24'h800001, 24'h7FFFFE, 24'hC0FFEE, 24'h8ACE13, 24, 32);
    endtask

    task automatic test_right24;
        run_scn("R5", 2'b10, 24'h000000, 24'h7F0001, 24'h912345, 24'h00FF00, 24, 32);
    endtask

    task automatic test_right16;
        run_scn("R6", 2'b11, 24'h008001, 24'h007FFF, 24'h00FFFF, 24'h001234, 16, 32);
    endtask

    task automatic test_short_words;
        run_scn("R7 left-aligned", 2'b01, 24'hC3A55A, 24'h8001FF, 24'h7E11AB, 24'hFFFFFF, 16, 16);
        run_scn("R7 R4 delayed",   2'b00, 24'hC3A55A, 24'h8001FF, 24'h7E11AB, 24'hFFFFFF, 16, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_left_aligned();
        test_delayed();
        test_right24();
        test_right16();
        test_short_words();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog got timeout exp completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule